// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block runs the register writes needed to move a CPU clock domain from one frequency to another while the domain's main PLL is reprogrammed. A request carries the old rate, the requested new rate and the current rate of an alternate clock source. The block looks the new rate up in a small table of allowed rates. On a hit, it parks the core clock on the alternate source. If that source is faster than the old rate, it also divides the source down in the same write. It then asks for the PLL to be reprogrammed and waits for lock. Last, it returns the core clock to the main source and programs the auxiliary dividers listed in the table entry. The order of those final writes depends on whether the rate goes up or down.

Every write leaves through one register write port. A core-control write uses a masked format: bits [31:16] of the data enable bits [15:0]. In the core-control register, bit 7 selects the clock source (1 = alternate, 0 = main) and bits [3:0] hold the core divider. The table is filled through a configuration port before any request is made.

Top module: `clk_rate_seq`

## Requirements
- R1: A request whose new rate matches no valid table entry raises `err` for exactly one cycle, one cycle after the request. It produces no write, and `busy` stays low.
- R2: When the alternate rate is above the old rate, the request is accepted with one write to `CORE_ADDR` in the cycle after the request. Its data is 0x008F0080 OR d, where d = ceil(alt/old) - 1. This switches the source to the alternate clock and sets the divider in the same write.
- R3: If d exceeds 15 (the largest value of the 4-bit divider field), the value 15 is written instead, and `clamp_warn` is high for that write's cycle only.
- R4: When the alternate rate is not above the old rate, the accepting write is 0x00800080. This touches only the source-select bit.
- R5: `pll_req` rises in the cycle after the accepting write and stays high until `pll_lock` is sampled high. It falls in the cycle in which the first post-lock slot is presented, and no write occurs while it is high.
- R6: When the new rate is above the old rate, the post-lock slots are: auxiliary slot 0, auxiliary slot 1, then the core restore write 0x008F0000 (main source, divider 0). There is one slot per cycle.
- R7: When the new rate is below the old rate, the post-lock slots are: the core restore write 0x008F0000, then auxiliary slot 0, then auxiliary slot 1.
- R8: An auxiliary slot whose table address is 0 leaves its cycle without a write. When the new rate equals the old rate, neither auxiliary slot is written.
- R9: `busy` is high from the accepting write until the cycle after the last post-lock slot. In that cycle `done` pulses for one cycle and `busy` is low. While `busy` is high, requests and configuration writes have no effect.
- R10: After reset the table holds no valid entries. A configuration write while idle makes its entry valid with the given rate and slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 2 | Table entry index |
| cfg_rate | input | 16 | Rate stored in the entry |
| cfg_addr | input | 24 | Auxiliary slot addresses, slot 1 in [23:12], slot 0 in [11:0] |
| cfg_val | input | 64 | Auxiliary slot data, slot 1 in [63:32], slot 0 in [31:0] |
| req_valid | input | 1 | Rate-change request strobe |
| req_old_rate | input | 16 | Rate before the change |
| req_new_rate | input | 16 | Requested rate |
| alt_rate | input | 16 | Current rate of the alternate source |
| pll_lock | input | 1 | PLL lock indication |
| pll_req | output | 1 | PLL reprogram request |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 12 | Register write address |
| wr_data | output | 32 | Register write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| clamp_warn | output | 1 | Divider clamp warning, with the accepting write |

## Verification
Take a request sampled at edge E. Its accepting write or `err` pulse is due in the cycle after E, and `pll_req` is due one cycle later. The first post-lock slot appears in the cycle after the edge that samples `pll_lock` high. The remaining two slots and the `done` pulse follow on consecutive cycles. For each request, the bench builds a queue of expected per-cycle output records from its own table model and arithmetic. It holds `pll_lock` low for a chosen number of cycles and pops one record at every falling edge, so each result is compared in exactly the cycle it is due. Idle cycles are compared against all-low outputs.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ARM  = 2'd1,
        SQ_WAIT = 2'd2,
        SQ_POST = 2'd3
    } seq_state_e;

endpackage

// File: rtl/csq_rate_table.sv
module csq_rate_table #(
    parameter int RATE_W  = 16,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int NUM_ENT = 4,
    parameter int AUX_N   = 2,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_ok,
    input  logic [IDX_W-1:0]          set_idx,
    input  logic [RATE_W-1:0]         set_rate,
    input  logic [AUX_N*ADDR_W-1:0]   set_addr,
    input  logic [AUX_N*DATA_W-1:0]   set_val,
    input  logic [RATE_W-1:0]         look_rate,
    output logic                      hit,
    output logic [IDX_W-1:0]          hit_idx,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [AUX_N*ADDR_W-1:0]   rd_addr,
    output logic [AUX_N*DATA_W-1:0]   rd_val
);

    typedef struct packed {
        logic                           vld;
        logic [RATE_W-1:0]              rate;
        logic [AUX_N-1:0][ADDR_W-1:0]   addr;
        logic [AUX_N-1:0][DATA_W-1:0]   val;
    } ent_t;

    ent_t [NUM_ENT-1:0] tbl_d, tbl_q;
    logic [NUM_ENT-1:0] match_vec;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_ok) begin
            tbl_d[set_idx].vld  = 1'b1;
            tbl_d[set_idx].rate = set_rate;
            tbl_d[set_idx].addr = set_addr;
            tbl_d[set_idx].val  = set_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_match
        assign match_vec[i] = tbl_q[i].vld && (tbl_q[i].rate == look_rate);
    end

    always_comb begin
        hit     = |match_vec;
        hit_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign rd_addr = tbl_q[rd_idx].addr;
    assign rd_val  = tbl_q[rd_idx].val;

    p_cfg_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (tbl_q[$past(set_idx)].vld && tbl_q[$past(set_idx)].rate == $past(set_rate)));

endmodule

// File: rtl/csq_alt_div.sv
module csq_alt_div #(
    parameter int RATE_W = 16,
    parameter int DIV_W  = 4
) (
    input  logic [RATE_W-1:0] alt_rate,
    input  logic [RATE_W-1:0] old_rate,
    output logic              need_div,
    output logic [DIV_W-1:0]  div_val,
    output logic              clamped
);

    localparam logic [RATE_W:0] DIV_MAX = (RATE_W+1)'((1 << DIV_W) - 1);

    logic [RATE_W:0] quot;
    logic [RATE_W:0] minus1;

    always_comb begin
        need_div = alt_rate > old_rate;
        quot     = '0;
        minus1   = '0;
        clamped  = 1'b0;
        div_val  = '0;
        if (need_div) begin
            if (old_rate == '0) begin
                clamped = 1'b1;
                div_val = DIV_MAX[DIV_W-1:0];
            end else begin
                quot    = ({1'b0, alt_rate} + {1'b0, old_rate} - 1'b1) / {1'b0, old_rate};
                minus1  = quot - 1'b1;
                clamped = minus1 > DIV_MAX;
                div_val = clamped ? DIV_MAX[DIV_W-1:0] : minus1[DIV_W-1:0];
            end
        end
    end

endmodule

// File: rtl/clk_rate_seq.sv
module clk_rate_seq
    import clk_seq_pkg::*;
#(
    parameter int RATE_W  = 16,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int NUM_ENT = 4,
    parameter int AUX_N   = 2,
    parameter int DIV_W   = 4,
    parameter int MUX_BIT = 7,
    parameter logic [ADDR_W-1:0] CORE_ADDR = 12'h044,
    localparam int IDX_W  = $clog2(NUM_ENT),
    localparam int STEP_W = $clog2(AUX_N + 2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [RATE_W-1:0]         cfg_rate,
    input  logic [AUX_N*ADDR_W-1:0]   cfg_addr,
    input  logic [AUX_N*DATA_W-1:0]   cfg_val,
    input  logic                      req_valid,
    input  logic [RATE_W-1:0]         req_old_rate,
    input  logic [RATE_W-1:0]         req_new_rate,
    input  logic [RATE_W-1:0]         alt_rate,
    input  logic                      pll_lock,
    output logic                      pll_req,
    output logic                      wr_en,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [DATA_W-1:0]         wr_data,
    output logic                      busy,
    output logic                      done,
    output logic                      err,
    output logic                      clamp_warn
);

    localparam int HALF = DATA_W / 2;
    localparam logic [HALF-1:0] MUX_M = HALF'(1) << MUX_BIT;
    localparam logic [HALF-1:0] DIV_M = HALF'((1 << DIV_W) - 1);
    localparam logic [DATA_W-1:0] PRE_PLAIN = {MUX_M, MUX_M};
    localparam logic [DATA_W-1:0] PRE_DIV   = {MUX_M | DIV_M, MUX_M};
    localparam logic [DATA_W-1:0] RESTORE   = {MUX_M | DIV_M, {HALF{1'b0}}};
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(AUX_N);

    typedef struct packed {
        seq_state_e          st;
        logic [STEP_W-1:0]   step;
        logic [IDX_W-1:0]    idx;
        logic                up;
        logic                down;
        logic                wr_en;
        logic [ADDR_W-1:0]   wr_addr;
        logic [DATA_W-1:0]   wr_data;
        logic                pll_req;
        logic                busy;
        logic                done;
        logic                err;
        logic                warn;
    } seq_t;

    seq_t s_d, s_q;

    logic                             hit;
    logic [IDX_W-1:0]                 hit_idx;
    logic [AUX_N-1:0][ADDR_W-1:0]     slot_addr;
    logic [AUX_N-1:0][DATA_W-1:0]     slot_val;
    logic                             need_div;
    logic [DIV_W-1:0]                 div_val;
    logic                             clamped;

    csq_rate_table #(
        .RATE_W (RATE_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_ENT(NUM_ENT),
        .AUX_N  (AUX_N)
    ) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (cfg_we && !s_q.busy),
        .set_idx  (cfg_idx),
        .set_rate (cfg_rate),
        .set_addr (cfg_addr),
        .set_val  (cfg_val),
        .look_rate(req_new_rate),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .rd_idx   (s_q.idx),
        .rd_addr  (slot_addr),
        .rd_val   (slot_val)
    );

    csq_alt_div #(
        .RATE_W(RATE_W),
        .DIV_W (DIV_W)
    ) u_div (
        .alt_rate(alt_rate),
        .old_rate(req_old_rate),
        .need_div(need_div),
        .div_val (div_val),
        .clamped (clamped)
    );

    // Post-lock slot that the next registered write will carry.
    logic [STEP_W-1:0]  sel_step;
    logic [STEP_W-1:0]  aux_k;
    logic               core_slot;
    logic [ADDR_W-1:0]  aux_addr;
    logic [DATA_W-1:0]  aux_val;
    logic               emit_en;
    logic [ADDR_W-1:0]  emit_addr;
    logic [DATA_W-1:0]  emit_data;

    always_comb begin
        sel_step  = (s_q.st == SQ_POST) ? s_q.step + 1'b1 : '0;
        core_slot = s_q.up ? (sel_step == LAST_STEP) : (sel_step == '0);
        aux_k     = s_q.up ? sel_step : sel_step - 1'b1;
        aux_addr  = '0;
        aux_val   = '0;
        for (int k = 0; k < AUX_N; k++) begin
            if (aux_k == STEP_W'(k)) begin
                aux_addr = slot_addr[k];
                aux_val  = slot_val[k];
            end
        end
        emit_en   = core_slot || ((aux_addr != '0) && (s_q.up || s_q.down));
        emit_addr = core_slot ? CORE_ADDR : aux_addr;
        emit_data = core_slot ? RESTORE : aux_val;
    end

    always_comb begin
        s_d       = s_q;
        s_d.wr_en = 1'b0;
        s_d.done  = 1'b0;
        s_d.err   = 1'b0;
        s_d.warn  = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    if (!hit) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.st      = SQ_ARM;
                        s_d.busy    = 1'b1;
                        s_d.idx     = hit_idx;
                        s_d.up      = req_new_rate > req_old_rate;
                        s_d.down    = req_new_rate < req_old_rate;
                        s_d.wr_en   = 1'b1;
                        s_d.wr_addr = CORE_ADDR;
                        s_d.wr_data = need_div ? (PRE_DIV | DATA_W'(div_val)) : PRE_PLAIN;
                        s_d.warn    = clamped;
                    end
                end
            end
            SQ_ARM: begin
                s_d.pll_req = 1'b1;
                s_d.st      = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (pll_lock) begin
                    s_d.pll_req = 1'b0;
                    s_d.st      = SQ_POST;
                    s_d.step    = '0;
                    s_d.wr_en   = emit_en;
                    s_d.wr_addr = emit_addr;
                    s_d.wr_data = emit_data;
                end
            end
            SQ_POST: begin
                if (s_q.step == LAST_STEP) begin
                    s_d.st   = SQ_IDLE;
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.step    = sel_step;
                    s_d.wr_en   = emit_en;
                    s_d.wr_addr = emit_addr;
                    s_d.wr_data = emit_data;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= SQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign pll_req    = s_q.pll_req;
    assign wr_en      = s_q.wr_en;
    assign wr_addr    = s_q.wr_addr;
    assign wr_data    = s_q.wr_data;
    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign err        = s_q.err;
    assign clamp_warn = s_q.warn;

    p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !wr_en));

    p_accept_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (wr_en && wr_addr == CORE_ADDR && wr_data[MUX_BIT]));

    p_warn_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_warn |-> (wr_en && $rose(busy)));

    p_pll_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_req && !pll_lock) |=> pll_req);

    p_pll_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pll_req |-> !wr_en);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

// File: tb/sim_clk_rate_seq.sv
module sim_clk_rate_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [15:0] cfg_rate = '0;
    logic [23:0] cfg_addr = '0;
    logic [63:0] cfg_val = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_old_rate = '0;
    logic [15:0] req_new_rate = '0;
    logic [15:0] alt_rate = '0;
    logic        pll_lock = 1'b0;
    logic        pll_req, wr_en, busy, done, err, clamp_warn;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;

    always #4 clk = ~clk;

    clk_rate_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_rate(cfg_rate),
        .cfg_addr(cfg_addr), .cfg_val(cfg_val),
        .req_valid(req_valid), .req_old_rate(req_old_rate),
        .req_new_rate(req_new_rate), .alt_rate(alt_rate),
        .pll_lock(pll_lock), .pll_req(pll_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .err(err), .clamp_warn(clamp_warn)
    );

    localparam logic [11:0] CORE = 12'h044;

    typedef struct {
        logic        en;
        logic [11:0] addr;
        logic [31:0] data;
        logic        bsy;
        logic        pll;
        logic        dn;
        logic        er;
        logic        wn;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;

    int          m_rate[4];
    bit          m_vld[4];
    logic [11:0] m_a[4][2];
    logic [31:0] m_v[4][2];

    task automatic push(input logic en, input logic [11:0] a, input logic [31:0] d,
                        input logic b, input logic p, input logic dn, input logic er,
                        input logic wn, input string tag);
        exp_t r;
        r.en = en; r.addr = a; r.data = d; r.bsy = b; r.pll = p;
        r.dn = dn; r.er = er; r.wn = wn; r.tag = tag;
        exp_q.push_back(r);
    endtask

    task automatic step_cycle();
        exp_t r;
        bit   bad;
        @(negedge clk);
        if (exp_q.size() > 0) r = exp_q.pop_front();
        else begin
            r.en = 0; r.addr = '0; r.data = '0; r.bsy = 0; r.pll = 0;
            r.dn = 0; r.er = 0; r.wn = 0; r.tag = "idle R9";
        end
        bad = (wr_en !== r.en) || (busy !== r.bsy) || (pll_req !== r.pll) ||
              (done !== r.dn) || (err !== r.er) || (clamp_warn !== r.wn);
        if (r.en && ((wr_addr !== r.addr) || (wr_data !== r.data))) bad = 1;
        checks++;
        if (bad) begin
            failures++;
            $display("FAIL %s: actual en=%0b a=%h d=%h busy=%0b pll=%0b done=%0b err=%0b warn=%0b expected en=%0b a=%h d=%h busy=%0b pll=%0b done=%0b err=%0b warn=%0b",
                     r.tag, wr_en, wr_addr, wr_data, busy, pll_req, done, err, clamp_warn,
                     r.en, r.addr, r.data, r.bsy, r.pll, r.dn, r.er, r.wn);
        end
    endtask

    task automatic cfg_write(input int idx, input int rate, input logic [11:0] a0,
                             input logic [31:0] v0, input logic [11:0] a1, input logic [31:0] v1);
        cfg_we = 1; cfg_idx = 2'(idx); cfg_rate = 16'(rate);
        cfg_addr = {a1, a0}; cfg_val = {v1, v0};
        m_vld[idx] = 1; m_rate[idx] = rate;
        m_a[idx][0] = a0; m_a[idx][1] = a1; m_v[idx][0] = v0; m_v[idx][1] = v1;
        step_cycle();
        cfg_we = 0;
    endtask

    // Request issued at a falling edge; pll_lock held low for dly cycles of pll_req.
    task automatic run_txn(input int old_r, input int new_r, input int alt_r,
                           input int dly, input bit inject, input string tag);
        int   idx = -1;
        int   dv = 0;
        bit   up, dn, nd, cl;
        logic [31:0] pre;
        for (int i = 3; i >= 0; i--) if (m_vld[i] && m_rate[i] == new_r) idx = i;
        req_valid = 1; req_old_rate = 16'(old_r); req_new_rate = 16'(new_r); alt_rate = 16'(alt_r);
        if (idx < 0) begin
            push(0, '0, '0, 0, 0, 0, 1, 0, {tag, " R1 miss"});
            push(0, '0, '0, 0, 0, 0, 0, 0, {tag, " R1 after miss"});
            step_cycle();
            req_valid = 0;
            step_cycle();
            return;
        end
        up = new_r > old_r; dn = new_r < old_r; nd = alt_r > old_r; cl = 0;
        if (nd) begin
            dv = (alt_r + old_r - 1) / old_r - 1;
            if (dv > 15) begin dv = 15; cl = 1; end
            pre = 32'h008F0080 | 32'(dv);
        end else pre = 32'h00800080;
        push(1, CORE, pre, 1, 0, 0, 0, cl, {tag, nd ? (cl ? " R3 clamp pre" : " R2 div pre") : " R4 plain pre"});
        for (int i = 0; i < dly; i++) push(0, '0, '0, 1, 1, 0, 0, 0, {tag, " R5 pll wait"});
        for (int s = 0; s < 3; s++) begin
            bit core; int k; logic [11:0] a; logic [31:0] v; bit en;
            core = up ? (s == 2) : (s == 0);
            k = up ? s : s - 1;
            if (core) begin a = CORE; v = 32'h008F0000; en = 1; end
            else begin a = m_a[idx][k]; v = m_v[idx][k]; en = (a != 0) && (up || dn); end
            push(en, a, v, 1, 0, 0, 0, 0, {tag, up ? " R6 up slot" : (dn ? " R7 down slot" : " R8 equal slot")});
        end
        push(0, '0, '0, 0, 0, 1, 0, 0, {tag, " R9 done"});
        push(0, '0, '0, 0, 0, 0, 0, 0, {tag, " R9 idle after"});
        step_cycle();
        req_valid = 0;
        for (int i = 0; i < dly; i++) begin
            step_cycle();
            if (inject && i == 0) begin
                req_valid = 1; req_new_rate = 16'd300; req_old_rate = 16'd100;
                cfg_we = 1; cfg_idx = 2'd0; cfg_rate = 16'd999;
            end
            if (i == 1) begin req_valid = 0; cfg_we = 0; end
        end
        pll_lock = 1;
        step_cycle();
        pll_lock = 0;
        for (int i = 0; i < 4; i++) step_cycle();
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_vld[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step_cycle();                       // reset state R9
        run_txn(50, 100, 250, 2, 0, "T0 empty table R10");
        cfg_write(0, 100, 12'h100, 32'hA0, 12'h104, 32'hA1);
        cfg_write(1, 200, 12'h100, 32'hB0, 12'h000, 32'hB1);
        cfg_write(2, 300, 12'h000, 32'hC0, 12'h104, 32'hC1);
        cfg_write(3, 400, 12'h108, 32'hD0, 12'h10C, 32'hD1);
        run_txn(100, 300, 250, 2, 0, "T1 up div R2 R6 R8");
        run_txn(400, 100, 250, 3, 1, "T2 down busy-ignore R4 R7 R9");
        run_txn(400, 100, 250, 2, 0, "T3 entry kept R9");
        run_txn(400, 999, 250, 2, 0, "T4 cfg ignored R9");
        run_txn(10, 200, 250, 1, 0, "T5 clamp R3");
        run_txn(400, 400, 100, 2, 0, "T6 equal R8");
        run_txn(100, 123, 250, 2, 0, "T7 miss R1");
        run_txn(125, 100, 250, 4, 0, "T8 exact R2");
        run_txn(250, 100, 250, 2, 0, "T9 alt equal R4");
        run_txn(15, 400, 240, 2, 0, "T10 div 15 no clamp R3");
        repeat (3) step_cycle();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule